// File: doc/BRIEF.md
# BIOS and Shadow RAM Region Decoder

This block sits in the host bridge of a 486-class PC. It keeps the few configuration bytes that decide where the top of the first megabyte is served from, and it classifies every CPU memory address into a destination. Each 32 KB segment between 0xC0000 and 0xFFFFF can be served by the BIOS ROM, by shadow DRAM, or be left to the expansion bus. The two 64 KB ROM windows also have aliases just below the 4 GB boundary, each with its own enable.

Software reaches the registers through a small word-wide register port. Each register byte has a lane strobe, so a write can change one byte and leave the rest. Reads return the register contents in the same cycle. The decoder takes a 32-bit address and, one clock later, gives a one-hot destination together with the ROM-relative byte offset of that address. The memory controller and the bus bridges use that result to steer the access.

Top module: `romshadow_decode`

## Requirements
- R1: After reset, the register word at byte offset 0x40 reads 0x00000000, the word at 0x44 reads 0x00000000, and the word at 0xD0 reads 0x0000FF78. The word at 0x40 holds the DRAM byte in bits 7:0. The word at 0x44 holds the shadow word in bits 15:0. The word at 0xD0 holds the BIOS byte in bits 7:0 and the ISA byte in bits 15:8. All other bits read 0.
- R2: A write changes only the register bytes whose lane strobe (cfg_be bit n covers data bits 8n+7:8n) is set. The two shadow bytes update independently of each other, and so do the BIOS and ISA bytes. Lanes that hold no register ignore the write.
- R3: A write to any offset other than 0x40, 0x44 or 0xD0 changes no register, and such offsets read 0. The low two address bits are ignored.
- R4: Addresses 0xFFFE0000–0xFFFEFFFF select ROM when BIOS bit 6 is 1. Addresses 0xFFFF0000–0xFFFFFFFF select ROM when BIOS bit 5 is 1. Otherwise these ranges are unclaimed.
- R5: With BIOS bit 6 set and shadow bits 5:4 both 0, the range 0xE0000–0xEFFFF selects ROM. With BIOS bit 5 set and shadow bits 7:6 both 0, the range 0xF0000–0xFFFFF selects ROM.
- R6: With BIOS bit 6 set and shadow bits 5:4 not both 0, 0xE0000–0xE7FFF goes to shadow DRAM if shadow bit 4 is 1, and 0xE8000–0xEFFFF goes to shadow DRAM if shadow bit 5 is 1. A half whose bit is 0 is unclaimed. Shadow bits 6 and 7 do the same for 0xF0000 and 0xF8000 under BIOS bit 5. If the enabling BIOS bit is 0, the whole 64 KB range is unclaimed.
- R7: Shadow bits 0, 1, 2 and 3 send the 32 KB blocks at 0xC0000, 0xC8000, 0xD0000 and 0xD8000 to shadow DRAM whatever the BIOS byte holds. A block whose bit is 0 is unclaimed.
- R8: 0x00000–0x9FFFF selects base DRAM when ISA bit 0 is 1, and is unclaimed otherwise. 0x100000–0x1FFFFFF always selects base DRAM. 0xA0000–0xBFFFF is always unclaimed.
- R9: region_sel is one-hot: bit 0 ROM, bit 1 shadow DRAM, bit 2 base DRAM, bit 3 unclaimed. Any address that no rule claims, for example 0x2000000–0xFFFDFFFF, selects unclaimed. During reset region_sel holds the unclaimed code.
- R10: rom_offset equals the decoded address modulo the 128 KB ROM size. It appears in the same cycle as that address's region_sel.
- R11: The decode result for an address sampled at a clock edge appears on the outputs after that edge. It uses the register values held before that same edge, so a register write affects addresses sampled from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_be | input | 4 | Byte-lane strobes for the write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| mem_addr | input | 32 | CPU memory address to classify |
| region_sel | output | 4 | One-hot destination: ROM, shadow, base DRAM, unclaimed |
| rom_offset | output | 17 | Address modulo the ROM size |

## Verification
Register reads are combinational, so the bench checks them 1 ns after it changes cfg_addr, in the same low clock phase. Decode results are due exactly one rising edge after mem_addr is driven. The driver tags each expected item with that edge's cycle number. The monitor compares the item at the falling edge of that cycle, so an early or late result fails as a mismatch. Each register write completes at one rising edge before the next probe is driven. This matches the rule that the decoder uses the register contents held before each edge.

// File: rtl/romshadow_pkg.sv
package romshadow_pkg;

    // destination index; the one-hot select is 1 << index
    typedef enum logic [1:0] {
        RGN_ROM    = 2'd0,
        RGN_SHADOW = 2'd1,
        RGN_BASE   = 2'd2,
        RGN_NONE   = 2'd3
    } region_e;

    // configuration register byte offsets
    localparam int CFG_OFF_DRAM   = 'h40;
    localparam int CFG_OFF_SHADOW = 'h44;
    localparam int CFG_OFF_BIOS   = 'hD0;

    // reset contents
    localparam logic [7:0]  RST_DRAM   = 8'h00;
    localparam logic [15:0] RST_SHADOW = 16'h0000;
    localparam logic [7:0]  RST_BIOS   = 8'h78;
    localparam logic [7:0]  RST_ISA    = 8'hFF;

    // BIOS byte bits that enable the E and F ROM ranges
    localparam int BIOS_E_BIT = 6;
    localparam int BIOS_F_BIT = 5;
    // ISA byte bit enabling low base memory
    localparam int ISA_LOW_BIT = 0;

    typedef struct packed {
        logic [7:0]  dram;
        logic [15:0] shadow;
        logic [7:0]  bios;
        logic [7:0]  isa;
    } cfg_t;

endpackage

// File: rtl/romshadow_cfg_regs.sv
module romshadow_cfg_regs
    import romshadow_pkg::*;
#(
    parameter int CFG_AW  = 8,
    parameter int NSHADOW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CFG_AW-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rom_en_e,
    output logic              rom_en_f,
    output logic              low_en,
    output logic [NSHADOW-1:0] shadow_map
);

    cfg_t cfg_d, cfg_q;
    int   word_off;

    always_comb begin
        word_off = int'({addr[CFG_AW-1:2], 2'b00});
    end

    // next-state
    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (word_off == CFG_OFF_DRAM) begin
                if (be[0]) cfg_d.dram = wdata[7:0];
            end else if (word_off == CFG_OFF_SHADOW) begin
                if (be[0]) cfg_d.shadow[7:0]  = wdata[7:0];
                if (be[1]) cfg_d.shadow[15:8] = wdata[15:8];
            end else if (word_off == CFG_OFF_BIOS) begin
                if (be[0]) cfg_d.bios = wdata[7:0];
                if (be[1]) cfg_d.isa  = wdata[15:8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{dram: RST_DRAM, shadow: RST_SHADOW, bios: RST_BIOS, isa: RST_ISA};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // read mux
    always_comb begin
        rdata = 32'h0;
        if (word_off == CFG_OFF_DRAM) begin
            rdata[7:0] = cfg_q.dram;
        end else if (word_off == CFG_OFF_SHADOW) begin
            rdata[15:0] = cfg_q.shadow;
        end else if (word_off == CFG_OFF_BIOS) begin
            rdata[15:0] = {cfg_q.isa, cfg_q.bios};
        end
    end

    assign rom_en_e   = cfg_q.bios[BIOS_E_BIT];
    assign rom_en_f   = cfg_q.bios[BIOS_F_BIT];
    assign low_en     = cfg_q.isa[ISA_LOW_BIT];
    assign shadow_map = cfg_q.shadow[NSHADOW-1:0];

endmodule

// File: rtl/romshadow_seg_map.sv
module romshadow_seg_map #(
    parameter int NSEG = 8
) (
    input  logic            rom_en_e,
    input  logic            rom_en_f,
    input  logic [NSEG-1:0] shadow_map,
    output logic [NSEG-1:0] seg_rom,
    output logic [NSEG-1:0] seg_sh
);

    // lower half of the segments shadow freely; upper half pair up under ROM enables
    localparam int NFREE = NSEG / 2;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k < NFREE) begin : g_free
            assign seg_rom[k] = 1'b0;
            assign seg_sh[k]  = shadow_map[k];
        end else begin : g_rom
            localparam int GRP  = (k - NFREE) / 2;
            localparam int PAIR = NFREE + 2 * GRP;
            logic en;
            logic pair_clear;
            assign en         = (GRP == 0) ? rom_en_e : rom_en_f;
            assign pair_clear = (shadow_map[PAIR +: 2] == 2'b00);
            assign seg_rom[k] = en & pair_clear;
            assign seg_sh[k]  = en & shadow_map[k];
        end
    end

endmodule

// File: rtl/romshadow_region_dec.sv
module romshadow_region_dec
    import romshadow_pkg::*;
#(
    parameter int          ROM_AW    = 17,
    parameter int          SEG_AW    = 15,
    parameter int          NSEG      = 8,
    parameter logic [31:0] SEG_BASE  = 32'h000C_0000,
    parameter logic [31:0] LOW_TOP   = 32'h000A_0000,
    parameter logic [31:0] HIGH_BASE = 32'h0010_0000,
    parameter logic [31:0] DRAM_TOP  = 32'h0200_0000
) (
    input  logic [31:0]     addr,
    input  logic            rom_en_e,
    input  logic            rom_en_f,
    input  logic            low_en,
    input  logic [NSEG-1:0] shadow_map,
    output region_e         rgn
);

    localparam int AREA_LSB = SEG_AW + $clog2(NSEG);

    logic [NSEG-1:0]          seg_rom;
    logic [NSEG-1:0]          seg_sh;
    logic                     in_area;
    logic                     in_alias;
    logic [AREA_LSB-SEG_AW-1:0] seg_idx;

    romshadow_seg_map #(.NSEG(NSEG)) u_seg (
        .rom_en_e  (rom_en_e),
        .rom_en_f  (rom_en_f),
        .shadow_map(shadow_map),
        .seg_rom   (seg_rom),
        .seg_sh    (seg_sh)
    );

    assign in_area  = ((addr >> AREA_LSB) == (SEG_BASE >> AREA_LSB));
    assign in_alias = &addr[31:ROM_AW];
    assign seg_idx  = addr[AREA_LSB-1:SEG_AW];

    always_comb begin
        rgn = RGN_NONE;
        if (in_alias) begin
            if (addr[ROM_AW-1] ? rom_en_f : rom_en_e) rgn = RGN_ROM;
        end else if (in_area) begin
            if (seg_rom[seg_idx])     rgn = RGN_ROM;
            else if (seg_sh[seg_idx]) rgn = RGN_SHADOW;
        end else if (addr < LOW_TOP) begin
            if (low_en) rgn = RGN_BASE;
        end else if (addr >= HIGH_BASE && addr < DRAM_TOP) begin
            rgn = RGN_BASE;
        end
    end

endmodule

// File: rtl/romshadow_decode.sv
module romshadow_decode
    import romshadow_pkg::*;
#(
    parameter int          ROM_BYTES = 131072,
    parameter int          CFG_AW    = 8,
    parameter int          SEG_BYTES = 32768,
    parameter int          NSEG      = 8,
    parameter logic [31:0] LOW_TOP   = 32'h000A_0000,
    parameter logic [31:0] HIGH_BASE = 32'h0010_0000,
    parameter logic [31:0] DRAM_TOP  = 32'h0200_0000,
    localparam int         ROM_AW    = $clog2(ROM_BYTES),
    localparam int         SEG_AW    = $clog2(SEG_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       mem_addr,
    output logic [3:0]        region_sel,
    output logic [ROM_AW-1:0] rom_offset
);

    localparam logic [31:0] SEG_BASE = 32'h0010_0000 - 32'(NSEG * SEG_BYTES);

    typedef struct packed {
        logic [3:0]        sel;
        logic [ROM_AW-1:0] off;
    } dec_out_t;

    logic            rom_en_e;
    logic            rom_en_f;
    logic            low_en;
    logic [NSEG-1:0] shadow_map;
    region_e         rgn;
    dec_out_t        out_d, out_q;

    romshadow_cfg_regs #(.CFG_AW(CFG_AW), .NSHADOW(NSEG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .addr      (cfg_addr),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .rom_en_e  (rom_en_e),
        .rom_en_f  (rom_en_f),
        .low_en    (low_en),
        .shadow_map(shadow_map)
    );

    romshadow_region_dec #(
        .ROM_AW   (ROM_AW),
        .SEG_AW   (SEG_AW),
        .NSEG     (NSEG),
        .SEG_BASE (SEG_BASE),
        .LOW_TOP  (LOW_TOP),
        .HIGH_BASE(HIGH_BASE),
        .DRAM_TOP (DRAM_TOP)
    ) u_dec (
        .addr      (mem_addr),
        .rom_en_e  (rom_en_e),
        .rom_en_f  (rom_en_f),
        .low_en    (low_en),
        .shadow_map(shadow_map),
        .rgn       (rgn)
    );

    always_comb begin
        out_d     = out_q;
        out_d.sel = 4'b0001 << rgn;
        out_d.off = mem_addr[ROM_AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{sel: 4'b1000, off: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign region_sel = out_q.sel;
    assign rom_offset = out_q.off;

endmodule

// File: rtl/romshadow_decode_chk.sv
module romshadow_decode_chk #(
    parameter int          ROM_AW    = 17,
    parameter logic [31:0] LOW_TOP   = 32'h000A_0000,
    parameter logic [31:0] HIGH_BASE = 32'h0010_0000,
    parameter logic [31:0] DRAM_TOP  = 32'h0200_0000
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       mem_addr,
    input logic [3:0]        region_sel,
    input logic [ROM_AW-1:0] rom_offset
);

    // R9: exactly one destination at all times
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(region_sel) == 1);

    // R10/R11: offset follows the sampled address one edge later
    p_offset_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rom_offset == $past(mem_addr[ROM_AW-1:0]));

    // R8: upper base DRAM always claimed
    p_himem_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= HIGH_BASE && mem_addr < DRAM_TOP) |=> region_sel == 4'b0100);

    // R8: video hole never claimed
    p_hole_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= LOW_TOP && mem_addr < 32'h000C_0000) |=> region_sel == 4'b1000);

    // R9: gap between top of DRAM and the ROM alias
    p_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_addr >= DRAM_TOP && !(&mem_addr[31:ROM_AW])) |=> region_sel == 4'b1000);

    // R4/R5: ROM is only chosen for the E/F range or the high alias
    p_romsrc_r4: assert property (@(posedge clk) disable iff (rst)
        region_sel[0] |-> (($past(mem_addr) >= 32'h000E_0000 && $past(mem_addr) < HIGH_BASE)
                           || (&$past(mem_addr[31:ROM_AW]))));

endmodule

bind romshadow_decode romshadow_decode_chk #(
    .ROM_AW   (ROM_AW),
    .LOW_TOP  (LOW_TOP),
    .HIGH_BASE(HIGH_BASE),
    .DRAM_TOP (DRAM_TOP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .region_sel(region_sel),
    .rom_offset(rom_offset)
);

// File: tb/romshadow_decode_test.sv
`timescale 1ns/1ps
module romshadow_decode_test;

    localparam logic [3:0] S_ROM = 4'b0001, S_SH = 4'b0010, S_BASE = 4'b0100, S_NONE = 4'b1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic [3:0]  region_sel;
    logic [16:0] rom_offset;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // bench-side register model
    logic [7:0]  m_dram = 8'h00, m_bios = 8'h78, m_isa = 8'hFF;
    logic [15:0] m_sh = 16'h0000;

    typedef struct {
        logic [3:0]  sel;
        logic [16:0] off;
        logic [31:0] addr;
        int          due;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    romshadow_decode uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
        .region_sel(region_sel), .rom_offset(rom_offset)
    );

    function automatic logic [3:0] model(input logic [31:0] a);
        logic en;
        logic [1:0] pair;
        if (a >= 32'hFFFE0000 && a <= 32'hFFFEFFFF) return m_bios[6] ? S_ROM : S_NONE;
        if (a >= 32'hFFFF0000) return m_bios[5] ? S_ROM : S_NONE;
        if (a < 32'h000A0000) return m_isa[0] ? S_BASE : S_NONE;
        if (a >= 32'h00100000 && a < 32'h02000000) return S_BASE;
        if (a >= 32'h000C0000 && a < 32'h000E0000)
            return m_sh[(a - 32'h000C0000) >> 15] ? S_SH : S_NONE;
        if (a >= 32'h000E0000 && a < 32'h00100000) begin
            en   = (a < 32'h000F0000) ? m_bios[6] : m_bios[5];
            pair = (a < 32'h000F0000) ? m_sh[5:4] : m_sh[7:6];
            if (!en) return S_NONE;
            if (pair == 2'b00) return S_ROM;
            return m_sh[(a - 32'h000C0000) >> 15] ? S_SH : S_NONE;
        end
        return S_NONE;
    endfunction

    function automatic string req_of(input logic [31:0] a);
        if (a >= 32'hFFFE0000) return "R4";
        if (a >= 32'h000C0000 && a < 32'h000E0000) return "R7";
        if (a >= 32'h000E0000 && a < 32'h00100000)
            return (model(a) == S_ROM) ? "R5" : "R6";
        if (a < 32'h00100000 || a < 32'h02000000) return "R8";
        return "R9";
    endfunction

    task automatic note(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: present an address, queue its expected result for the next edge
    task automatic probe(input logic [31:0] a);
        exp_t e;
        @(negedge clk);
        mem_addr = a;
        e.sel  = model(a);
        e.off  = a[16:0];
        e.addr = a;
        e.due  = cyc + 1;
        e.req  = req_of(a);
        sb.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            note(region_sel == e.sel, e.req, $sformatf("sel @%h", e.addr),
                 32'(region_sel), 32'(e.sel));
            note(rom_offset == e.off, "R10", $sformatf("offset @%h", e.addr),
                 32'(rom_offset), 32'(e.off));
        end
    end

    task automatic wr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = off; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
        case ({off[7:2], 2'b00})
            8'h40: if (be[0]) m_dram = d[7:0];
            8'h44: begin
                if (be[0]) m_sh[7:0]  = d[7:0];
                if (be[1]) m_sh[15:8] = d[15:8];
            end
            8'hD0: begin
                if (be[0]) m_bios = d[7:0];
                if (be[1]) m_isa  = d[15:8];
            end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] off, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = off;
        #1;
        note(cfg_rdata == exp, req, $sformatf("read %h", off), cfg_rdata, exp);
    endtask

    task automatic rd_all(input string req);
        rd(8'h40, {24'h0, m_dram}, req);
        rd(8'h44, {16'h0, m_sh}, req);
        rd(8'hD0, {16'h0, m_isa, m_bios}, req);
    endtask

    task automatic sweep();
        for (int k = 0; k < 8; k++) begin
            probe(32'h000C0000 + 32'(k) * 32'h8000);
            probe(32'h000C7FFF + 32'(k) * 32'h8000);
        end
        probe(32'h00000000); probe(32'h0009FFFF); probe(32'h000A0000);
        probe(32'h000BFFFF); probe(32'h00100000); probe(32'h01FFFFFF);
        probe(32'h02000000); probe(32'h80001234); probe(32'hFFFDFFFF);
        probe(32'hFFFE0000); probe(32'hFFFEFFFF); probe(32'hFFFF0000);
        probe(32'hFFFFFFFF); probe(32'hFFFFABCD);
    endtask

    task automatic set_cfg(input logic [7:0] bios, input logic [15:0] sh, input logic [7:0] isa);
        wr(8'h44, 4'b0011, {16'h0, sh});
        wr(8'hD0, 4'b0011, {16'h0, isa, bios});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: unclaimed while in reset
        note(region_sel == S_NONE, "R9", "sel in reset", 32'(region_sel), 32'(S_NONE));
        rst = 1'b0;
        // R1 reset contents
        rd(8'h40, 32'h00000000, "R1");
        rd(8'h44, 32'h00000000, "R1");
        rd(8'hD0, 32'h0000FF78, "R1");
        sweep();

        // R2 byte lanes on the shadow word
        wr(8'h44, 4'b0001, 32'h0000ABCD);
        rd(8'h44, 32'h000000CD, "R2");
        wr(8'h45, 4'b0010, 32'h00001200);
        rd(8'h44, 32'h000012CD, "R2");
        // R2 lanes without a register ignored
        wr(8'hD0, 4'b1100, 32'hEEDD0000);
        rd(8'hD0, 32'h0000FF78, "R2");
        wr(8'hD0, 4'b0010, 32'h00005500);
        rd(8'hD0, 32'h00005578, "R2");
        wr(8'h40, 4'b1111, 32'hA5A5A53C);
        rd(8'h40, 32'h0000003C, "R2");
        // R3 unmapped offsets
        wr(8'h48, 4'b1111, 32'hFFFFFFFF);
        wr(8'hD4, 4'b1111, 32'hFFFFFFFF);
        rd(8'h48, 32'h0, "R3");
        rd(8'hD4, 32'h0, "R3");
        rd_all("R3");

        // decode sweeps under varied settings (R4..R8, R11)
        set_cfg(8'h78, 16'h0000, 8'hFF); sweep();
        set_cfg(8'h78, 16'h00F0, 8'h00); sweep();
        set_cfg(8'h60, 16'h0050, 8'h01); sweep();
        set_cfg(8'h18, 16'h00FF, 8'h00); sweep();
        set_cfg(8'h20, 16'h0025, 8'hFE); sweep();
        set_cfg(8'h40, 16'hFFA0, 8'h01); sweep();
        set_cfg(8'h40, 16'h000A, 8'h01); sweep();

        // R11: write lands between two probes of the same address
        set_cfg(8'h78, 16'h0000, 8'hFF);
        probe(32'h000E4000);
        wr(8'h44, 4'b0001, 32'h00000010);
        probe(32'h000E4000);
        probe(32'h000EC000);

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule